// File: doc/BRIEF.md
# Indexed Interrupt-Routing Register Window

This block is a memory-mapped register file for an I/O interrupt router. Software reaches every internal register through two 32-bit windows: a select window that holds an index, and a data window that reads or writes whatever register the index names. Behind the data window sit an identity word, a constant version word, an arbitration word that never changes after reset, some general storage words, and a routing table that holds two 32-bit words for each interrupt pin.

For every pin the block also keeps a decoded interrupt vector and a decoded destination, which it drives continuously as outputs. Downstream routing logic uses them. A zero vector byte is treated as "not programmed" and does not disturb the decoded vector. A destination byte of all ones is widened to a 32-bit broadcast mask. The bus port is a single-cycle request interface. Reads return data combinationally in the cycle the request is accepted, and a request to an unknown offset raises an error flag.

Top module: `irq_route_regs`

## Requirements
- R1: Only offsets 0x00 (select) and 0x10 (data) are legal. A request at any other offset drives `bus_err` high in the same cycle, returns read data 0 and changes no state. A legal request leaves `bus_err` low.
- R2: A write at offset 0x00 loads the full 32-bit select register. A read at offset 0x00 returns the select register.
- R3: Select index 0 is an identity word that the data window can write and read back.
- R4: Select index 1 always reads 0x00170011 through the data window, and writes to it are ignored.
- R5: Select index 2 is the arbitration word. It reads its stored value (zero after reset), and data-window writes do not change it.
- R6: Indices 3 through 0x3F are storage words that read back the last value written. Pin n (0..23) uses index 0x10+2n as its low word and index 0x10+2n+1 as its high word.
- R7: A data-window read with a select index of 0x40 or above returns 0xFFFFFFFF.
- R8: A data-window write with a select index of 0x40 or above is discarded: no stored word, vector or destination changes.
- R9: Bits [7:0] of a low-word write become the pin's `pin_vector` byte (pin n at bits [8n+7:8n]) only when that byte is nonzero. The table word itself is always stored.
- R10: Bits [31:24] of a high-word write set the pin's `pin_dest` word (pin n at bits [32n+31:32n]). The value 0xFF becomes 0xFFFFFFFF, and any other value is zero-extended.
- R11: Synchronous reset clears the select register, all stored words, and every decoded vector and destination to zero.
- R12: Read data and the error flag are valid in the same cycle as the request. Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Illegal offset flag, same cycle |
| pin_vector | output | 192 | Decoded vector byte per pin |
| pin_dest | output | 768 | Decoded destination word per pin |

## Verification
Read data and the error flag are combinational, so the bench drives a request just after a falling edge and samples `bus_rdata` and `bus_err` one time step later, before the next rising edge. Writes land at that rising edge, so the decoded `pin_vector` and `pin_dest` outputs and any later read are checked only after the edge, against a model that is updated after the access. Random traffic that mixes illegal offsets, out-of-range indices and zero vector bytes is interleaved with directed cases at the first and last pin and at the protected indices.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 8;

    typedef enum logic [1:0] {
        WIN_SEL  = 2'd0,
        WIN_DATA = 2'd1,
        WIN_BAD  = 2'd2
    } win_e;

    typedef struct packed {
        logic             in_range;
        logic             is_ident;
        logic             is_version;
        logic             is_arb;
        logic             is_table;
        logic             hi_word;
        logic [IDX_W-1:0] word;
        logic [IDX_W-1:0] pin;
    } idx_info_t;

    function automatic logic [DATA_W-1:0] widen_dest(input logic [7:0] b);
        if (b == 8'hFF) return {DATA_W{1'b1}};
        return {{(DATA_W-8){1'b0}}, b};
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_PINS   = 24,
    parameter int unsigned TABLE_BASE = 16,
    parameter int unsigned SEL_OFS    = 0,
    parameter int unsigned DATA_OFS   = 16,
    parameter int unsigned IDENT_IDX  = 0,
    parameter int unsigned VER_IDX    = 1,
    parameter int unsigned ARB_IDX    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] sel,
    output win_e              win,
    output idx_info_t         info
);
    localparam int unsigned WORDS = TABLE_BASE + 2 * NUM_PINS;

    always_comb begin
        if (addr == ADDR_W'(SEL_OFS))       win = WIN_SEL;
        else if (addr == ADDR_W'(DATA_OFS)) win = WIN_DATA;
        else                                win = WIN_BAD;
    end

    always_comb begin
        info            = '0;
        info.in_range   = (sel < DATA_W'(WORDS));
        info.word       = sel[IDX_W-1:0];
        info.is_ident   = (sel == DATA_W'(IDENT_IDX));
        info.is_version = (sel == DATA_W'(VER_IDX));
        info.is_arb     = (sel == DATA_W'(ARB_IDX));
        info.is_table   = info.in_range && (sel >= DATA_W'(TABLE_BASE));
        info.hi_word    = sel[0] ^ TABLE_BASE[0];
        info.pin        = IDX_W'((sel[IDX_W-1:0] - IDX_W'(TABLE_BASE)) >> 1);
    end

endmodule

// File: rtl/irq_route_words.sv
module irq_route_words
    import irq_route_pkg::*;
#(
    parameter int unsigned WORDS   = 64,
    parameter int unsigned ARB_IDX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                mem[g] <= '0;
            else if (we && waddr == IDX_W'(g))      mem[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (raddr == IDX_W'(i)) rdata = mem[i];
        end
    end

    AST_ARB_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mem[ARB_IDX])); // R5

endmodule

// File: rtl/irq_route_pin.sv
module irq_route_pin
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        vec,
    output logic [DATA_W-1:0] dest
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec  <= '0;
            dest <= '0;
        end else begin
            if (wr_lo && wdata[7:0] != 8'd0) vec <= wdata[7:0];
            if (wr_hi)                       dest <= widen_dest(wdata[31:24]);
        end
    end

    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (rst)
        !$stable(vec) |-> (vec != 8'd0)); // R9

    AST_DEST_FORM: assert property (@(posedge clk) disable iff (rst)
        (dest == {DATA_W{1'b1}}) || (dest[DATA_W-1:8] == '0)); // R10

    AST_DEST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hi |=> $stable(dest)); // R10

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_PINS   = 24,
    parameter int unsigned TABLE_BASE = 16,
    parameter int unsigned SEL_OFS    = 0,
    parameter int unsigned DATA_OFS   = 16,
    parameter logic [31:0] VERSION    = 32'h0017_0011
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_err,
    output logic [NUM_PINS*8-1:0]    pin_vector,
    output logic [NUM_PINS*32-1:0]   pin_dest
);
    localparam int unsigned WORDS     = TABLE_BASE + 2 * NUM_PINS;
    localparam int unsigned IDENT_IDX = 0;
    localparam int unsigned VER_IDX   = 1;
    localparam int unsigned ARB_IDX   = 2;

    logic [DATA_W-1:0] sel_q;
    win_e              win;
    idx_info_t         info;
    logic              sel_we;
    logic              data_we;
    logic [DATA_W-1:0] word_rd;

    irq_route_decode #(
        .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .TABLE_BASE(TABLE_BASE),
        .SEL_OFS(SEL_OFS), .DATA_OFS(DATA_OFS), .IDENT_IDX(IDENT_IDX),
        .VER_IDX(VER_IDX), .ARB_IDX(ARB_IDX)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel_q),
        .win  (win),
        .info (info)
    );

    assign sel_we  = bus_valid && bus_write && (win == WIN_SEL);
    assign data_we = bus_valid && bus_write && (win == WIN_DATA) &&
                     info.in_range && !info.is_version && !info.is_arb;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (sel_we) sel_q <= bus_wdata;
    end

    irq_route_words #(.WORDS(WORDS), .ARB_IDX(ARB_IDX)) u_words (
        .clk   (clk),
        .rst   (rst),
        .we    (data_we),
        .waddr (info.word),
        .wdata (bus_wdata),
        .raddr (info.word),
        .rdata (word_rd)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic hit;
        assign hit = data_we && info.is_table && (info.pin == IDX_W'(p));
        irq_route_pin u_pin (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (hit && !info.hi_word),
            .wr_hi (hit && info.hi_word),
            .wdata (bus_wdata),
            .vec   (pin_vector[p*8 +: 8]),
            .dest  (pin_dest[p*32 +: 32])
        );
    end

    assign bus_err = bus_valid && (win == WIN_BAD);

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (win)
                WIN_SEL:  bus_rdata = sel_q;
                WIN_DATA: begin
                    if (!info.in_range)       bus_rdata = '1;
                    else if (info.is_version) bus_rdata = VERSION;
                    else                      bus_rdata = word_rd;
                end
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_BAD_OFS_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> $stable(sel_q) && $stable(pin_vector) && $stable(pin_dest)); // R1

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == ADDR_W'(SEL_OFS))
        |=> (sel_q == $past(bus_wdata))); // R2

    AST_OOR_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == ADDR_W'(DATA_OFS) &&
         sel_q >= DATA_W'(WORDS))
        |=> $stable(pin_vector) && $stable(pin_dest)); // R8

    AST_OOR_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(DATA_OFS) &&
         sel_q >= DATA_W'(WORDS)) |-> (bus_rdata == '1)); // R7

endmodule

// File: tb/irq_route_regs_tb_top.sv
module irq_route_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;
    localparam int NW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [NP*8-1:0]  pin_vector;
    logic [NP*32-1:0] pin_dest;

    int n_tests = 0, n_fail = 0;

    logic [31:0] m_sel;
    logic [31:0] m_word [NW];
    logic [7:0]  m_vec  [NP];
    logic [31:0] m_dest [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_regs dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_vector(pin_vector), .pin_dest(pin_dest)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(input logic [31:0] s);
        if (s >= 32'(NW)) return 32'hFFFF_FFFF;
        if (s == 32'd1)   return 32'h0017_0011;
        return m_word[s[5:0]];
    endfunction

    function automatic string req_of(input logic [7:0] a, input logic [31:0] s);
        if (a != 8'h00 && a != 8'h10) return "R1";
        if (a == 8'h00) return "R2";
        if (s >= 32'(NW)) return "R7";
        case (s)
            32'd0: return "R3";
            32'd1: return "R4";
            32'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model_apply(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) m_sel = d;
        else if (a == 8'h10 && m_sel < 32'(NW) && m_sel != 32'd1 && m_sel != 32'd2) begin
            m_word[m_sel[5:0]] = d;
            if (m_sel >= 32'd16) begin
                int p = int'((m_sel - 32'd16) >> 1);
                if (m_sel[0] == 1'b0) begin
                    if (d[7:0] != 8'd0) m_vec[p] = d[7:0];
                end else begin
                    m_dest[p] = (d[31:24] == 8'hFF) ? 32'hFFFF_FFFF : {24'd0, d[31:24]};
                end
            end
        end
    endtask

    // One bus access; read data and error sampled in the request cycle (R12).
    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        bit          exp_err;
        string       rq;
        exp_err = (a != 8'h00 && a != 8'h10);
        rq = req_of(a, m_sel);
        if (wr || exp_err) exp_rd = 32'd0;
        else if (a == 8'h00) exp_rd = m_sel;
        else exp_rd = exp_data(m_sel);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        #1;
        check(bus_err == exp_err, exp_err ? "R1" : "R1 legal", {31'd0, bus_err}, {31'd0, exp_err});
        check(bus_rdata == exp_rd, rq, bus_rdata, exp_rd);
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
        if (wr && !exp_err) model_apply(a, d);
    endtask

    task automatic check_pins(input string tag);
        for (int p = 0; p < NP; p++) begin
            check(pin_vector[p*8 +: 8] == m_vec[p], {tag, " R9 vector"},
                  {24'd0, pin_vector[p*8 +: 8]}, {24'd0, m_vec[p]});
            check(pin_dest[p*32 +: 32] == m_dest[p], {tag, " R10 dest"},
                  pin_dest[p*32 +: 32], m_dest[p]);
        end
    endtask

    task automatic sweep_words();
        for (int i = 0; i < NW + 2; i++) begin
            access(1'b1, 8'h00, 32'(i));
            access(1'b0, 8'h10, 32'd0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_sel = '0;
        for (int i = 0; i < NW; i++) m_word[i] = '0;
        for (int p = 0; p < NP; p++) begin m_vec[p] = '0; m_dest[p] = '0; end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        access(1'b0, 8'h00, 32'd0);
        check_pins("R11");
        sweep_words();

        // R2 select round trip
        access(1'b1, 8'h00, 32'h0000_0010);
        access(1'b0, 8'h00, 32'd0);
        // R9 zero low byte stored but vector kept
        access(1'b1, 8'h10, 32'h1234_5600);
        access(1'b0, 8'h10, 32'd0);
        check_pins("R9 zero");
        access(1'b1, 8'h10, 32'h0000_00AB);
        check_pins("R9 set");
        // R10 broadcast and plain
        access(1'b1, 8'h00, 32'h11);
        access(1'b1, 8'h10, 32'hFF00_0000);
        check_pins("R10 bcast");
        access(1'b1, 8'h10, 32'h05AA_AAAA);
        check_pins("R10 plain");
        // R6 last pin
        access(1'b1, 8'h00, 32'h3E);
        access(1'b1, 8'h10, 32'h0000_0077);
        access(1'b1, 8'h00, 32'h3F);
        access(1'b1, 8'h10, 32'hFE00_0000);
        access(1'b0, 8'h10, 32'd0);
        check_pins("R6 last");
        // R4 version, R5 arbitration, R3 identity
        access(1'b1, 8'h00, 32'd1);
        access(1'b1, 8'h10, 32'hDEAD_BEEF);
        access(1'b0, 8'h10, 32'd0);
        access(1'b1, 8'h00, 32'd2);
        access(1'b1, 8'h10, 32'hCAFE_F00D);
        access(1'b0, 8'h10, 32'd0);
        access(1'b1, 8'h00, 32'd0);
        access(1'b1, 8'h10, 32'h0F00_0000);
        access(1'b0, 8'h10, 32'd0);
        // R7, R8 out of range
        access(1'b1, 8'h00, 32'h40);
        access(1'b0, 8'h10, 32'd0);
        access(1'b1, 8'h10, 32'h0000_00FF);
        access(1'b1, 8'h00, 32'hFFFF_FFFF);
        access(1'b0, 8'h10, 32'd0);
        access(1'b1, 8'h10, 32'hFF00_0055);
        check_pins("R8");
        // R1 illegal offsets
        access(1'b1, 8'h04, 32'h0000_0012);
        access(1'b0, 8'h00, 32'd0);
        access(1'b0, 8'h11, 32'd0);
        access(1'b1, 8'hF0, 32'h1234_5678);
        sweep_words();

        // Constrained random traffic
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [7:0]  a;
            logic [31:0] d;
            bit          wr;
            wr = ($urandom_range(0, 1) == 1);
            if (r < 35) begin
                a = 8'h00;
                d = ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 72));
            end else if (r < 92) begin
                a = 8'h10;
                d = $urandom();
                if ($urandom_range(0, 3) == 0) d[7:0] = 8'h00;
                if ($urandom_range(0, 3) == 0) d[31:24] = 8'hFF;
            end else begin
                a = 8'($urandom_range(1, 255));
                if (a == 8'h10) a = 8'h20;
                d = $urandom();
            end
            access(wr, a, d);
            if (n % 50 == 49) check_pins("random");
        end
        sweep_words();
        check_pins("final");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule